// File: doc/BRIEF.md
# VCO Coarse Band Calibrator

This block chooses the coarse tuning code of a voltage-controlled oscillator before the synthesizer loop is closed. It works by comparing frequencies. The block runs on the reference clock. For each trial code it waits for the oscillator to settle. It then counts edges of the oscillator, after a fixed prescaler, over a window of reference cycles. That count is compared with the count the requested division ratio calls for. A successive-approximation search decides one code bit per trial. Every trial's absolute error is compared with the smallest error stored so far, and the code that gave it is kept.

After the last trial, the output shows the stored best code rather than the code the search ended on. The block then computes a charge-pump current code that scales with the division ratio and inversely with the gain of the chosen band. This keeps the loop bandwidth about the same across bands. The controller raises `done` and holds both codes until it is started again.

Top module: `vco_band_cal`

## Requirements
- R1: During reset, `band_code`, `cp_code` and `done` are all zero.
- R2: A clock edge that samples `start` high while idle begins a run. From that edge on, `done` is low and `band_code` shows the trial code with only its top bit set (32 with defaults).
- R3: Each trial lasts SETTLE_CYC + WIN_CYC + 1 cycles, which is 529 with defaults. First come SETTLE_CYC settle cycles, then WIN_CYC cycles in which each sampled `fb_tick` adds one to the count, then one compare cycle. `fb_tick` is ignored outside the window, and `band_code` does not change during settle or count.
- R4: The target is (div_ratio × WIN_CYC) >> PRE_LOG2, which equals `div_ratio` with defaults. A higher band code gives a higher frequency. If the count is above the target, the bit under test is cleared. The next lower bit is then set for the next trial. Bits are tested from the MSB down to bit 0, and a seventh trial measures the fully resolved code.
- R5: After the search, `band_code` is the visited code with the smallest |count − target|. On a tie, the earlier trial wins.
- R6: `cp_code` = floor((div_ratio × CP_K + g/2) / g), where g = KV_BASE + band code. The result is clamped to the range 1 to 2^CP_W − 1 (defaults: CP_K 20, KV_BASE 16, CP_W 7).
- R7: `done` rises exactly 7 × (SETTLE_CYC + WIN_CYC + 1) + DIV_W + ceil(log2 CP_K) + 3 cycles after the accepting edge, which is 3720 with defaults. It stays high, with both codes unchanged, until the next accepted `start`.
- R8: `start` is ignored while a run is in progress.
- R9: `div_ratio` is captured at the accepting edge. Later changes do not affect the run.
- R10: A target below the lowest band's count gives band 0. A target above the highest band's count gives band 2^BAND_W − 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Start request, sampled only when idle |
| div_ratio | input | DIV_W | Requested integer division ratio |
| fb_tick | input | 1 | One pulse per prescaled oscillator edge, synchronous to clk |
| band_code | output | BAND_W | Coarse band code: the trial code while searching, the best code afterwards |
| cp_code | output | CP_W | Charge-pump current setting |
| done | output | 1 | Calibration finished; the codes are valid |

## Verification
The assertions assume that `fb_tick` is a clean single-cycle pulse, synchronous to `clk`, with at most one pulse per cycle. They also assume that `start` is the only way out of idle. The bench models the oscillator as a phase accumulator advanced on the falling edge, with a rate that rises strictly with the band code, so each pulse lasts exactly one cycle. All inputs, including `start` pulses and `div_ratio` changes made in the middle of a run, are driven on falling edges. Every value the design samples is therefore stable at the rising edge.

// File: rtl/vcal_pkg.sv
// Package: shared state encoding for the band calibrator.
// Assumes nothing beyond being compiled before every other design file.
package vcal_pkg;

    // Controller phases of one calibration run, in the order they occur.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SETTLE  = 3'd1,
        ST_COUNT   = 3'd2,
        ST_CMP     = 3'd3,
        ST_BW_LOAD = 3'd4,
        ST_BW_DIV  = 3'd5,
        ST_BW_FIN  = 3'd6
    } vcal_state_e;

endpackage

// File: rtl/vcal_trial_timer.sv
// Module: vcal_trial_timer
// Times the settle interval and the counting window of one trial. It also counts
// oscillator pulses that fall inside the window.
// Assumes: settle_en and count_en are never high together, fb_tick is at most
// one pulse per cycle, and SETTLE_CYC >= 1.
module vcal_trial_timer #(
    parameter int SETTLE_CYC = 16,
    parameter int WIN_CYC    = 512,
    parameter int CNT_W      = $clog2(WIN_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             settle_en,
    input  logic             count_en,
    input  logic             fb_tick,
    output logic             settle_last,
    output logic             win_last,
    output logic [CNT_W-1:0] edge_cnt
);

    localparam int LONGEST = (SETTLE_CYC > WIN_CYC) ? SETTLE_CYC : WIN_CYC;
    localparam int TMR_W   = (LONGEST > 1) ? $clog2(LONGEST) : 1;

    logic [TMR_W-1:0] tmr_q;
    logic             phase_end;

    assign settle_last = settle_en && (tmr_q == TMR_W'(SETTLE_CYC - 1));
    assign win_last    = count_en  && (tmr_q == TMR_W'(WIN_CYC - 1));
    assign phase_end   = settle_last || win_last;

    // Phase timer: counts cycles in settle or count and restarts at each phase end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if ((settle_en || count_en) && !phase_end) begin
            tmr_q <= tmr_q + 1'b1;
        end else begin
            tmr_q <= '0;
        end
    end

    // Pulse counter: cleared while settling, advanced by pulses inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_cnt <= '0;
        end else if (settle_en) begin
            edge_cnt <= '0;
        end else if (count_en && fb_tick) begin
            edge_cnt <= edge_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/vcal_sar.sv
// Module: vcal_sar
// Successive-approximation band search that keeps the best code seen. Each
// compare step measures the error of the current trial, stores the trial if its
// error is strictly smaller than the stored one, and then decides the bit under
// test.
// Assumes: a higher code gives a higher frequency, and init and step are never
// high together.
module vcal_sar #(
    parameter int BAND_W = 6,
    parameter int CNT_W  = 10,
    parameter int TGT_W  = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              step,
    input  logic [CNT_W-1:0]  meas_cnt,
    input  logic [TGT_W-1:0]  target,
    output logic [BAND_W-1:0] trial_code,
    output logic [BAND_W-1:0] best_code,
    output logic              last_trial
);

    localparam logic [BAND_W-1:0] TOP_BIT = {1'b1, {(BAND_W-1){1'b0}}};

    logic [BAND_W-1:0] mask_q;
    logic [TGT_W-1:0]  best_err_q;
    logic [TGT_W-1:0]  cnt_ext;
    logic [TGT_W-1:0]  err;
    logic              too_fast;
    logic              better;

    assign cnt_ext    = TGT_W'(meas_cnt);
    assign too_fast   = cnt_ext > target;
    assign err        = too_fast ? (cnt_ext - target) : (target - cnt_ext);
    assign better     = err < best_err_q;
    assign last_trial = (mask_q == '0);

    // Search register: starts at the MSB trial and resolves one bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trial_code <= '0;
            mask_q     <= '0;
        end else if (init) begin
            trial_code <= TOP_BIT;
            mask_q     <= TOP_BIT;
        end else if (step && !last_trial) begin
            trial_code <= (too_fast ? (trial_code & ~mask_q) : trial_code) | (mask_q >> 1);
            mask_q     <= mask_q >> 1;
        end
    end

    // Best-so-far store: the earliest trial with the smallest error wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_code  <= '0;
            best_err_q <= '1;
        end else if (init) begin
            best_err_q <= '1;
        end else if (step && better) begin
            best_code  <= trial_code;
            best_err_q <= err;
        end
    end

endmodule

// File: rtl/vcal_cp_calc.sv
// Module: vcal_cp_calc
// Works out the charge-pump code round(div * CP_K / gain), where the band gain is
// KV_BASE + band. A restoring divider produces one quotient bit per step, and the
// result is clamped to the range 1 to 2^CP_W-1.
// Assumes: load comes one cycle before a run of exactly NUM_W step cycles.
module vcal_cp_calc #(
    parameter int DIV_W   = 9,
    parameter int BAND_W  = 6,
    parameter int CP_W    = 7,
    parameter int CP_K    = 20,
    parameter int KV_BASE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [DIV_W-1:0]  div_ratio,
    input  logic [BAND_W-1:0] band,
    output logic              last_step,
    output logic [CP_W-1:0]   cp_sat
);

    localparam int NUM_W  = DIV_W + $clog2(CP_K) + 1;
    localparam int GAIN_W = $clog2(KV_BASE + (1 << BAND_W));
    localparam int IT_W   = $clog2(NUM_W);
    localparam int CP_MAX = (1 << CP_W) - 1;

    logic [GAIN_W-1:0] gain_now;
    logic [GAIN_W-1:0] gain_q;
    logic [NUM_W-1:0]  dvd_q;
    logic [NUM_W-1:0]  quo_q;
    logic [GAIN_W-1:0] rem_q;
    logic [GAIN_W:0]   rem_sh;
    logic              fits;
    logic [IT_W-1:0]   it_q;

    assign gain_now  = GAIN_W'(KV_BASE) + GAIN_W'(band);
    assign rem_sh    = {rem_q, dvd_q[NUM_W-1]};
    assign fits      = rem_sh >= {1'b0, gain_q};
    assign last_step = step && (it_q == IT_W'(NUM_W - 1));

    // Divider datapath: loads the rounded numerator, then one restoring step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_q <= '0;
            dvd_q  <= '0;
            quo_q  <= '0;
            rem_q  <= '0;
            it_q   <= '0;
        end else if (load) begin
            gain_q <= gain_now;
            dvd_q  <= NUM_W'(div_ratio) * NUM_W'(CP_K) + NUM_W'(gain_now >> 1);
            quo_q  <= '0;
            rem_q  <= '0;
            it_q   <= '0;
        end else if (step) begin
            rem_q  <= fits ? GAIN_W'(rem_sh - {1'b0, gain_q}) : GAIN_W'(rem_sh);
            quo_q  <= {quo_q[NUM_W-2:0], fits};
            dvd_q  <= dvd_q << 1;
            it_q   <= it_q + 1'b1;
        end
    end

    // Clamp: keep the quotient within the current range, never below one step.
    always_comb begin
        if (quo_q > NUM_W'(CP_MAX)) begin
            cp_sat = CP_W'(CP_MAX);
        end else if (quo_q == '0) begin
            cp_sat = CP_W'(1);
        end else begin
            cp_sat = quo_q[CP_W-1:0];
        end
    end

endmodule

// File: rtl/vco_band_cal.sv
// Module: vco_band_cal (top)
// Automatic coarse band calibration by frequency comparison. It sequences seven
// trials (settle, count, compare), then the charge-pump computation, then done.
// Assumes: fb_tick is synchronous to clk with at most one pulse per cycle, and
// clk is the reference clock.
module vco_band_cal #(
    parameter int BAND_W     = 6,
    parameter int DIV_W      = 9,
    parameter int CP_W       = 7,
    parameter int CP_K       = 20,
    parameter int KV_BASE    = 16,
    parameter int SETTLE_CYC = 16,
    parameter int WIN_CYC    = 512,
    parameter int PRE_LOG2   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIV_W-1:0]  div_ratio,
    input  logic              fb_tick,
    output logic [BAND_W-1:0] band_code,
    output logic [CP_W-1:0]   cp_code,
    output logic              done
);

    import vcal_pkg::*;

    localparam int CNT_W = $clog2(WIN_CYC + 1);
    localparam int TGT_W = DIV_W + CNT_W;

    vcal_state_e       state_q;
    logic [DIV_W-1:0]  div_q;
    logic [TGT_W-1:0]  target;
    logic              settle_last;
    logic              win_last;
    logic [CNT_W-1:0]  edge_cnt;
    logic [BAND_W-1:0] trial_code;
    logic [BAND_W-1:0] best_code;
    logic              last_trial;
    logic              div_last;
    logic [CP_W-1:0]   cp_sat;
    logic              accept;
    logic              in_search;

    assign accept    = (state_q == ST_IDLE) && start;
    assign in_search = (state_q == ST_SETTLE) || (state_q == ST_COUNT) || (state_q == ST_CMP);
    assign target    = TGT_W'((TGT_W'(div_q) * TGT_W'(WIN_CYC)) >> PRE_LOG2);
    assign band_code = in_search ? trial_code : best_code;

    vcal_trial_timer #(
        .SETTLE_CYC (SETTLE_CYC),
        .WIN_CYC    (WIN_CYC),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .settle_en   (state_q == ST_SETTLE),
        .count_en    (state_q == ST_COUNT),
        .fb_tick     (fb_tick),
        .settle_last (settle_last),
        .win_last    (win_last),
        .edge_cnt    (edge_cnt)
    );

    vcal_sar #(
        .BAND_W (BAND_W),
        .CNT_W  (CNT_W),
        .TGT_W  (TGT_W)
    ) u_sar (
        .clk        (clk),
        .rst_n      (rst_n),
        .init       (accept),
        .step       (state_q == ST_CMP),
        .meas_cnt   (edge_cnt),
        .target     (target),
        .trial_code (trial_code),
        .best_code  (best_code),
        .last_trial (last_trial)
    );

    vcal_cp_calc #(
        .DIV_W   (DIV_W),
        .BAND_W  (BAND_W),
        .CP_W    (CP_W),
        .CP_K    (CP_K),
        .KV_BASE (KV_BASE)
    ) u_cp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (state_q == ST_BW_LOAD),
        .step      (state_q == ST_BW_DIV),
        .div_ratio (div_q),
        .band      (best_code),
        .last_step (div_last),
        .cp_sat    (cp_sat)
    );

    // Run sequencer: trials, then bandwidth computation, then publish the results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            div_q   <= '0;
            cp_code <= '0;
            done    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        div_q   <= div_ratio;
                        done    <= 1'b0;
                        state_q <= ST_SETTLE;
                    end
                end
                ST_SETTLE:  if (settle_last) state_q <= ST_COUNT;
                ST_COUNT:   if (win_last)    state_q <= ST_CMP;
                ST_CMP:     state_q <= last_trial ? ST_BW_LOAD : ST_SETTLE;
                ST_BW_LOAD: state_q <= ST_BW_DIV;
                ST_BW_DIV:  if (div_last)    state_q <= ST_BW_FIN;
                ST_BW_FIN: begin
                    cp_code <= cp_sat;
                    done    <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vcal_checker.sv
// Module: vcal_checker
// Temporal checks on the band calibrator, attached to the top module by bind.
// Assumes: the same clock and reset as the design.
module vcal_checker #(
    parameter int BAND_W = 6,
    parameter int DIV_W  = 9,
    parameter int CP_W   = 7
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  done,
    input logic [BAND_W-1:0]     band_code,
    input logic [CP_W-1:0]       cp_code,
    input logic [DIV_W-1:0]      div_q,
    input vcal_pkg::vcal_state_e state_q
);

    import vcal_pkg::*;

    localparam logic [BAND_W-1:0] TOP_BIT = {1'b1, {(BAND_W-1){1'b0}}};

    // R2: a start accepted while done is high clears done and loads the MSB trial.
    assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (!done && band_code == TOP_BIT));

    // R3: the band code stays put while the oscillator settles and is counted.
    assert_code_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE || state_q == ST_COUNT) |=> $stable(band_code));

    // R4: one search step changes at most the bit under test and the bit below it.
    assert_sar_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CMP) |=> (state_q != ST_SETTLE ||
                                 $countones(band_code ^ $past(band_code)) <= 2));

    // R6: a published charge-pump code is never zero.
    assert_cp_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cp_code != '0));

    // R7: done holds until a new start is accepted.
    assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R7: results do not move while done is held.
    assert_result_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> ($stable(band_code) && $stable(cp_code)));

    // R9: the captured division ratio is frozen for the whole run.
    assert_div_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(div_q));

endmodule

bind vco_band_cal vcal_checker #(
    .BAND_W (BAND_W),
    .DIV_W  (DIV_W),
    .CP_W   (CP_W)
) u_vcal_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .done      (done),
    .band_code (band_code),
    .cp_code   (cp_code),
    .div_q     (div_q),
    .state_q   (state_q)
);

// File: tb/vco_band_cal_bench.sv
// Bench for vco_band_cal. A behavioural oscillator model drives fb_tick, and a
// timeline reference model predicts band_code, cp_code and done on every clock.
module vco_band_cal_bench;

    localparam int BAND_W = 6, DIV_W = 9, CP_W = 7, CP_K = 20, KV_BASE = 16;
    localparam int S = 16, W = 512, PRE_LOG2 = 9;
    localparam int T = S + W + 1;
    localparam int TAIL = DIV_W + $clog2(CP_K) + 3;
    localparam int LAT = 7 * T + TAIL;
    localparam int NB = 1 << BAND_W;
    localparam int CP_MAX = (1 << CP_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [DIV_W-1:0] div_ratio = '0;
    logic fb_tick = 1'b0;
    logic [BAND_W-1:0] band_code;
    logic [CP_W-1:0] cp_code;
    logic done;

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_on = 0;

    always #4 clk = ~clk;

    vco_band_cal #(
        .BAND_W(BAND_W), .DIV_W(DIV_W), .CP_W(CP_W), .CP_K(CP_K), .KV_BASE(KV_BASE),
        .SETTLE_CYC(S), .WIN_CYC(W), .PRE_LOG2(PRE_LOG2)
    ) u_vco_band_cal (
        .clk(clk), .rst_n(rst_n), .start(start), .div_ratio(div_ratio),
        .fb_tick(fb_tick), .band_code(band_code), .cp_code(cp_code), .done(done)
    );

    // Oscillator model: pulse rate in 1/1024 per cycle, strictly rising with band.
    function automatic int rate_of(input int b);
        return 100 + 14 * b;
    endfunction

    function automatic int cp_ref(input int n, input int b);
        int g, q;
        g = KV_BASE + b;
        q = (n * CP_K + g / 2) / g;
        if (q > CP_MAX) q = CP_MAX;
        if (q < 1) q = 1;
        return q;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    int acc = 0;
    always @(negedge clk) begin
        acc = acc + rate_of(int'(band_code));
        if (acc >= 1024) begin
            acc = acc - 1024;
            fb_tick <= 1'b1;
        end else begin
            fb_tick <= 1'b0;
        end
    end

    // Reference model, stepped on each rising edge from bench-driven inputs only.
    int m_busy, m_pos, m_t, m_cnt, m_code, m_mask, m_best, m_berr, m_div, m_tgt, m_tail;
    int exp_band = 0, exp_cp = 0, exp_done = 0;
    int visited_err[$];
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; exp_band = 0; exp_cp = 0; exp_done = 0; m_best = 0;
        end else if (m_busy == 0) begin
            if (start) begin
                m_busy = 1; m_div = int'(div_ratio);
                m_tgt = (m_div * W) >> PRE_LOG2;
                m_code = NB / 2; m_mask = NB / 2; m_berr = 1 << 30;
                m_pos = 0; m_cnt = 0; m_t = 0; m_tail = 0;
                exp_done = 0; exp_band = m_code;
                visited_err.delete();
            end
        end else if (m_t < 7) begin
            m_pos++;
            if (m_pos > S && m_pos <= S + W && fb_tick) m_cnt++;
            if (m_pos == T) begin
                int e;
                e = (m_cnt > m_tgt) ? m_cnt - m_tgt : m_tgt - m_cnt;
                visited_err.push_back(e);
                if (e < m_berr) begin m_berr = e; m_best = m_code; end
                if (m_mask != 0) begin
                    if (m_cnt > m_tgt) m_code = m_code & ~m_mask;
                    m_mask = m_mask >> 1;
                    m_code = m_code | m_mask;
                end
                m_t++; m_pos = 0; m_cnt = 0;
                exp_band = (m_t == 7) ? m_best : m_code;
            end
        end else begin
            m_tail++;
            if (m_tail == TAIL) begin
                exp_cp = cp_ref(m_div, m_best); exp_done = 1; m_busy = 0;
            end
        end
    end

    // Per-clock comparison of all outputs against the model.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R4", "band_code", int'(band_code), exp_band);
            chk("R6", "cp_code", int'(cp_code), exp_cp);
            chk("R7", "done", int'(done), exp_done);
        end
    end

    task automatic summary_and_end();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            n_bad++;
            $display("FAIL R7 watchdog expired actual=%0d expected<=%0d", wd, 100000);
            summary_and_end();
        end
    end

    // One calibration run; optionally pokes start and div_ratio mid-run (R8, R9).
    task automatic run_cal(input int n, input bit poke);
        int cyc, min_err, ideal_min, ideal_b;
        div_ratio = DIV_W'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2", "done after start", int'(done), 0);
        chk("R2", "first trial code", int'(band_code), NB / 2);
        cyc = 0;
        while (!done && cyc < LAT + 50) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 1000) begin start = 1'b1; div_ratio = DIV_W'(n + 37); end
            if (poke && cyc == 1001) begin start = 1'b0; div_ratio = DIV_W'(n); end
            if (poke && cyc == 1500) div_ratio = DIV_W'(n + 90);
        end
        chk(poke ? "R8" : "R7", "latency", cyc, LAT);
        chk(poke ? "R9" : "R6", "cp formula", int'(cp_code), cp_ref(n, int'(band_code)));
        min_err = 1 << 30;
        foreach (visited_err[i]) if (visited_err[i] < min_err) min_err = visited_err[i];
        chk("R5", "visited traffic size", visited_err.size(), 7);
        chk("R5", "best error is minimum", m_berr, min_err);
        ideal_min = 1 << 30;
        for (int b = 0; b < NB; b++) begin
            int e2;
            e2 = rate_of(b) * W / 1024 - n;
            if (e2 < 0) e2 = -e2;
            if (e2 < ideal_min) ideal_min = e2;
        end
        ideal_b = rate_of(int'(band_code)) * W / 1024 - n;
        if (ideal_b < 0) ideal_b = -ideal_b;
        chk("R5", "near-optimal band", int'(ideal_b <= ideal_min + 8), 1);
        repeat (3) @(negedge clk);
        chk("R7", "done held", int'(done), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cmp_on = 1;
        chk("R1", "band_code in reset", int'(band_code), 0);
        chk("R1", "cp_code in reset", int'(cp_code), 0);
        chk("R1", "done in reset", int'(done), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R3", "no run without start", int'(done), 0);
        run_cal(250, 1'b0);
        run_cal(40, 1'b0);
        chk("R10", "low target gives band 0", int'(band_code), 0);
        run_cal(511, 1'b0);
        chk("R10", "high target gives top band", int'(band_code), NB - 1);
        chk("R6", "cp saturates high", int'(cp_code), CP_MAX);
        run_cal(333, 1'b0);
        run_cal(120, 1'b1);
        summary_and_end();
    end

endmodule